// File: doc/BRIEF.md
# Bidirectional Phase Step Controller

This block keeps the phase pointer that drives a fine output-clock phase interpolator or delay line. It runs on a fast system clock and watches two asynchronous inputs: a step strobe and a lead/lag level. Each rising edge of the strobe moves the pointer by one fine step. The lead/lag level sampled at that edge picks the direction. A high level advances the output clock, which is a decrement of the delay code. A low level retards it, which is an increment. The pointer wraps at a modulus set by a 2-bit post-divider select.

There are two ways to use the block. In closed-loop alignment, an external clock drives the lead/lag input and the strobe comes from a reference. In fixed-offset mode, the lead/lag input is tied to a static level and the number of strobes programs the delay. In every run of 32 strobe edges, the last edge is counted but deliberately not applied. Each applied step produces a one-cycle update pulse and a direction flag.

Top module: `phase_step_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the phase code is 0, the update pulse is 0 and the direction flag is 0.
- R2: A strobe rising edge with lead/lag high advances the phase: the code decrements by one, and 0 wraps to modulus-1. The direction flag is 1 for an advance.
- R3: A strobe rising edge with lead/lag low retards the phase: the code increments by one, and modulus-1 wraps to 0. The direction flag is 0 for a retard.
- R4: The modulus depends on the select code: 768 for 2'b11, 1536 for 2'b10 and 3072 for 2'b01.
- R5: Strobe edges are counted in groups of 32. The 32nd edge of each group produces no update pulse and leaves the code unchanged.
- R6: Each applied step raises the update pulse for exactly one system clock cycle. The direction flag is valid in that cycle and holds until the next applied step.
- R7: The phase code and the update pulse change at the third rising system clock edge after the strobe input rises.
- R8: While the select is 2'b00, strobe edges are ignored and the pointer holds.
- R9: Any change of the select clears both the phase code and the 32-edge group counter to 0.
- R10: Without a strobe rising edge the pointer holds, whatever the lead/lag input does.
- R11: With lead/lag held static, N strobe edges from a cleared state move the code by N - floor(N/32) steps in that direction, modulo the modulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stepStrobeAsync | input | 1 | Asynchronous step strobe; each rising edge requests one step |
| leadLagAsync | input | 1 | Asynchronous direction level: 1 advances, 0 retards |
| divSel | input | 2 | Post-divider select: 11, 10 or 01; 00 is unsupported |
| phaseCode | output | 12 | Current delay code |
| updPulse | output | 1 | One-cycle pulse on each applied step |
| lastDirAdv | output | 1 | Direction of the last applied step: 1 for advance |

## Verification
The results appear on a fixed schedule:
- A strobe rise reaches the outputs at the third clock edge: two synchronizer edges, then the pointer register.
- A select change clears the pointer at the first edge after the change.

Every bench check samples at a falling edge, once those edges have passed. The single-step test probes the second, third and fourth edges. Vector runs wait several idle cycles after the last strobe before they read the code. Skipped edges are detected by counting update pulses at every falling edge across a whole burst.

// File: rtl/phase_step_pkg.sv
package phase_step_pkg;

  // Command passed from control to datapath each cycle
  typedef struct packed {
    logic clear;    // select changed: zero the pointer
    logic step;     // apply one step this cycle
    logic advance;  // 1 = decrement code, 0 = increment
  } stepCmd_t;

  // Left shift applied to the base step count for a select code
  function automatic logic [1:0] selShift(input logic [1:0] sel);
    case (sel)
      2'b11:   selShift = 2'd0;
      2'b10:   selShift = 2'd1;
      2'b01:   selShift = 2'd2;
      default: selShift = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/pstep_sync.sv
module pstep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic dOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], dIn};
  end

  assign dOut = chain[STAGES-1];
endmodule

// File: rtl/pstep_ctrl.sv
module pstep_ctrl
  import phase_step_pkg::*;
#(
  parameter int GROUP = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stbSync,
  input  logic       llSync,
  input  logic [1:0] divSel,
  output stepCmd_t   cmd
);
  localparam int GRP_W = $clog2(GROUP);
  localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(GROUP - 1);

  logic             stbPrev;
  logic [GRP_W-1:0] grpCnt;
  logic [1:0]       selPrev;
  logic             rise;
  logic             selValid;
  logic             selChg;

  assign rise     = stbSync & ~stbPrev;
  assign selValid = (divSel != 2'b00);
  assign selChg   = (divSel != selPrev);

  always_comb begin
    cmd.clear   = selChg;
    cmd.step    = rise & selValid & ~selChg & (grpCnt != GRP_LAST);
    cmd.advance = llSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stbPrev <= 1'b0;
      grpCnt  <= '0;
      selPrev <= 2'b11;
    end else begin
      stbPrev <= stbSync;
      selPrev <= divSel;
      if (selChg)
        grpCnt <= '0;
      else if (rise && selValid)
        grpCnt <= (grpCnt == GRP_LAST) ? '0 : grpCnt + 1'b1;
    end
  end
endmodule

// File: rtl/pstep_dpath.sv
module pstep_dpath
  import phase_step_pkg::*;
#(
  parameter int BASE_STEPS = 768,
  parameter int CODE_W     = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepCmd_t          cmd,
  input  logic [1:0]        divSel,
  output logic [CODE_W-1:0] phaseCode,
  output logic              updPulse,
  output logic              lastDirAdv
);
  logic [CODE_W-1:0] modulus;
  logic [CODE_W-1:0] topCode;
  logic [CODE_W-1:0] nextCode;

  assign modulus = CODE_W'(BASE_STEPS) << selShift(divSel);
  assign topCode = modulus - 1'b1;

  always_comb begin
    if (cmd.advance)
      nextCode = (phaseCode == '0) ? topCode : phaseCode - 1'b1;
    else
      nextCode = (phaseCode == topCode) ? '0 : phaseCode + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCode  <= '0;
      updPulse   <= 1'b0;
      lastDirAdv <= 1'b0;
    end else begin
      updPulse <= cmd.step & ~cmd.clear;
      if (cmd.clear) begin
        phaseCode <= '0;
      end else if (cmd.step) begin
        phaseCode  <= nextCode;
        lastDirAdv <= cmd.advance;
      end
    end
  end
endmodule

// File: rtl/phase_step_ctrl.sv
module phase_step_ctrl
  import phase_step_pkg::*;
#(
  parameter  int BASE_STEPS  = 768,
  parameter  int GROUP       = 32,
  parameter  int SYNC_STAGES = 2,
  localparam int CODE_W      = $clog2(BASE_STEPS * 4 + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepStrobeAsync,
  input  logic              leadLagAsync,
  input  logic [1:0]        divSel,
  output logic [CODE_W-1:0] phaseCode,
  output logic              updPulse,
  output logic              lastDirAdv
);
  logic     stbSync;
  logic     llSync;
  stepCmd_t cmd;

  pstep_sync #(.STAGES(SYNC_STAGES)) u_stbSync (
    .clk(clk), .rstN(rstN), .dIn(stepStrobeAsync), .dOut(stbSync)
  );

  pstep_sync #(.STAGES(SYNC_STAGES)) u_llSync (
    .clk(clk), .rstN(rstN), .dIn(leadLagAsync), .dOut(llSync)
  );

  pstep_ctrl #(.GROUP(GROUP)) u_ctrl (
    .clk(clk), .rstN(rstN), .stbSync(stbSync), .llSync(llSync),
    .divSel(divSel), .cmd(cmd)
  );

  pstep_dpath #(.BASE_STEPS(BASE_STEPS), .CODE_W(CODE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .divSel(divSel),
    .phaseCode(phaseCode), .updPulse(updPulse), .lastDirAdv(lastDirAdv)
  );
endmodule

// File: rtl/phase_step_checker.sv
module phase_step_checker #(
  parameter int BASE_STEPS = 768,
  parameter int CODE_W     = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        divSel,
  input logic [CODE_W-1:0] phaseCode,
  input logic              updPulse,
  input logic              lastDirAdv
);
  function automatic logic [CODE_W-1:0] modOf(input logic [1:0] sel);
    case (sel)
      2'b10:   modOf = CODE_W'(BASE_STEPS * 2);
      2'b01:   modOf = CODE_W'(BASE_STEPS * 4);
      default: modOf = CODE_W'(BASE_STEPS);
    endcase
  endfunction

  // R1: reset state
  always @(posedge clk) begin
    if (!rstN) a_r1_reset_state: assert (phaseCode == '0 && !updPulse && !lastDirAdv);
  end

  a_r2_advance_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (updPulse && lastDirAdv && $stable(divSel)) |->
      phaseCode == (($past(phaseCode) == '0) ? modOf(divSel) - 1'b1 : $past(phaseCode) - 1'b1));

  a_r3_delay_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (updPulse && !lastDirAdv && $stable(divSel)) |->
      phaseCode == (($past(phaseCode) == modOf(divSel) - 1'b1) ? '0 : $past(phaseCode) + 1'b1));

  a_r4_in_range: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(divSel) && divSel != 2'b00) |-> phaseCode < modOf(divSel));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    updPulse |=> !updPulse);

  a_r8_idle_select: assert property (@(posedge clk) disable iff (!rstN)
    (divSel == 2'b00 && $stable(divSel)) |-> !updPulse);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!updPulse && phaseCode != '0) |-> $stable(phaseCode));
endmodule

bind phase_step_ctrl phase_step_checker #(.BASE_STEPS(BASE_STEPS), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .divSel(divSel), .phaseCode(phaseCode),
  .updPulse(updPulse), .lastDirAdv(lastDirAdv)
);

// File: tb/phase_step_ctrl_bench.sv
module phase_step_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stb = 1'b0;
  logic        lead = 1'b0;
  logic [1:0]  divSel = 2'b11;
  logic [11:0] phaseCode;
  logic        updPulse;
  logic        lastDirAdv;

  int checks = 0;
  int errors = 0;
  int pulseCnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  phase_step_ctrl u_phase_step_ctrl (
    .clk(clk), .rstN(rstN), .stepStrobeAsync(stb), .leadLagAsync(lead),
    .divSel(divSel), .phaseCode(phaseCode), .updPulse(updPulse), .lastDirAdv(lastDirAdv)
  );

  always @(negedge clk) if (updPulse) pulseCnt++;

  // {select, lead/lag, edge count, expected code}
  localparam int NVEC = 10;
  localparam logic [26:0] VEC [NVEC] = '{
    {2'b11, 1'b0, 12'd5,   12'd5},    // R3 delay
    {2'b11, 1'b1, 12'd3,   12'd765},  // R2 advance wrap
    {2'b10, 1'b1, 12'd1,   12'd1535}, // R4 1536
    {2'b01, 1'b1, 12'd1,   12'd3071}, // R4 3072
    {2'b11, 1'b0, 12'd32,  12'd31},   // R5
    {2'b11, 1'b0, 12'd192, 12'd186},  // R11
    {2'b10, 1'b1, 12'd40,  12'd1497}, // R11
    {2'b01, 1'b0, 12'd64,  12'd62},   // R11
    {2'b11, 1'b1, 12'd800, 12'd761},  // R11 multiple wraps
    {2'b00, 1'b0, 12'd10,  12'd0}     // R8
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) stb = 1'b1;
      idle(2);
      stb = 1'b0;
      idle(2);
    end
    idle(5);
  endtask

  task automatic clearTo(input logic [1:0] sel);
    @(negedge clk) divSel = 2'b00;
    idle(4);
    divSel = sel;
    idle(4);
  endtask

  initial begin
    idle(3);
    check("R1 code", phaseCode, 0);
    check("R1 pulse", updPulse, 0);
    check("R1 dir", lastDirAdv, 0);
    @(negedge clk) rstN = 1'b1;
    idle(3);
    check("R1 code after release", phaseCode, 0);

    for (int v = 0; v < NVEC; v++) begin
      clearTo(VEC[v][26:25]);
      lead = VEC[v][24];
      strobes(int'(VEC[v][23:12]));
      check($sformatf("R11 vector %0d code", v), phaseCode, int'(VEC[v][11:0]));
    end

    // R7/R6 single delay step timing
    clearTo(2'b11);
    lead = 1'b0;
    @(negedge clk) stb = 1'b1;
    idle(2);
    check("R7 no pulse at edge 2", updPulse, 0);
    check("R7 code at edge 2", phaseCode, 0);
    idle(1);
    check("R7 pulse at edge 3", updPulse, 1);
    check("R7 code at edge 3", phaseCode, 1);
    check("R6 dir retard", lastDirAdv, 0);
    idle(1);
    check("R6 pulse one cycle", updPulse, 0);
    stb = 1'b0;
    idle(3);

    // R2 advance then R3 wrap up
    clearTo(2'b11);
    lead = 1'b1;
    strobes(1);
    check("R2 wrap 0 to 767", phaseCode, 767);
    check("R6 dir advance held", lastDirAdv, 1);
    lead = 1'b0;
    strobes(1);
    check("R3 wrap 767 to 0", phaseCode, 0);

    // R5 skip counted by pulses
    clearTo(2'b11);
    pulseCnt = 0;
    strobes(32);
    check("R5 pulses in 32 edges", pulseCnt, 31);
    pulseCnt = 0;
    strobes(1);
    check("R5 next group applies", pulseCnt, 1);

    // R9 select change clears pointer and group counter
    clearTo(2'b11);
    strobes(5);
    check("R9 setup", phaseCode, 5);
    @(negedge clk) divSel = 2'b10;
    idle(3);
    check("R9 code cleared", phaseCode, 0);
    strobes(31);
    check("R9 group counter cleared", phaseCode, 31);

    // R10 lead/lag toggling without strobes
    pulseCnt = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk) lead = ~lead;
      idle(1);
    end
    idle(4);
    check("R10 code held", phaseCode, 31);
    check("R10 no pulses", pulseCnt, 0);

    // R8 select 00 ignores strobes
    @(negedge clk) divSel = 2'b00;
    idle(4);
    pulseCnt = 0;
    strobes(8);
    check("R8 no pulses", pulseCnt, 0);
    check("R8 code held", phaseCode, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule